// File: doc/BRIEF.md
# Operand Store Maintenance Unit

This block carries out the maintenance commands of a small associative operand store whose user lines hold a tag, a value, a used bit and an altered bit. Software reaches it by writing special control locations, modelled as a single write port with a select code and a data word. The unit can wipe the status of every user line at once, put the replacement pointer back to line 0, walk all user lines writing back the altered ones before emptying them, and test whether any valid line falls inside a block given as an address plus a don't-care mask. The store keeps its reserved interrupt lines in the top indices, and no command ever touches them.

The store itself sits outside. It presents the tags, used bits and altered bits of its user lines, answers a line read index with that line's value, and applies the one-cycle clear strobes this unit sends. The unit also owns the cyclic replacement pointer that the refill logic advances. The purge walk talks to the backing memory through a request/acknowledge writeback channel. The result of a search lands in a test-flag bit that a later conditional branch reads.

Top module: `opstore_maint`

## Requirements
- R1: After reset, ptr_o selects line 0 (ptr_o == 1), busy_o, wb_req_o, srch_mute_o and test_flag_o are 0, and clr_o is all zero.
- R2: A control write with select 0 (invalidate) when idle sets clr_o bits 0..27 for exactly the next cycle, leaves bits 28..31 at 0, and raises no writeback.
- R3: The pointer is one-hot in ptr_o (bit i = line i). A write with select 1 moves it to line 0 on the next edge. Each idle cycle with ptr_step_i high moves it one line up, with line 27 wrapping to line 0. A select 1 write in the same cycle as a step wins.
- R4: A write with select 2 (purge) when idle raises busy_o from the next cycle and puts the pointer on line 0. The walk then examines one line per step from line 0 up to line 27.
- R5: During a purge, a line that is both used and altered holds wb_req_o high, with wb_addr_o equal to its tag and wb_data_o equal to its value, until wb_ack_i. The pointer does not move before the acknowledge.
- R6: When the walk finishes a line (at once if not used-and-altered, at the acknowledge otherwise), clr_o has only that line's bit set in the next cycle and the pointer moves up. After line 27, busy_o drops and the pointer is back on line 0.
- R7: A write with select 3 loads the search mask. A write with select 4 loads the search address and starts a compare. A mask bit of 1 excludes that tag bit from the compare.
- R8: test_flag_o takes, two edges after the select 4 write, the OR over user lines of (used and all unmasked tag bits equal to the address). Several lines may match. The flag changes at no other time.
- R9: srch_mute_o, which suppresses the store's multiple-match error, is high for exactly the compare cycle that follows each accepted select 4 write.
- R10: clr_o bits 28..31 (reserved lines) are never set, and reserved lines never feed the search.
- R11: While busy_o is high, every control write and ptr_step_i is ignored. Select codes 5 to 7 are ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Control location write strobe |
| csr_sel_i | input | 3 | Control location select (0 invalidate, 1 pointer reset, 2 purge, 3 mask, 4 address) |
| csr_data_i | input | TAG_W | Control write data (mask or block address) |
| ptr_step_i | input | 1 | Advance the replacement pointer after a refill |
| line_tag_i | input | N_USER*TAG_W | Tags of the user lines, line i at bits i*TAG_W |
| line_used_i | input | N_USER | Used bits of the user lines |
| line_alt_i | input | N_USER | Altered bits of the user lines |
| rd_idx_o | output | IDX_W | Line whose value the store presents on rd_value_i |
| rd_value_i | input | VAL_W | Value of line rd_idx_o |
| wb_req_o | output | 1 | Writeback request |
| wb_ack_i | input | 1 | Writeback acknowledge |
| wb_addr_o | output | TAG_W | Writeback address (line tag) |
| wb_data_o | output | VAL_W | Writeback data (line value) |
| clr_o | output | N_LINES | One-cycle strobe clearing used and altered bits of each set line |
| ptr_o | output | N_USER | One-hot replacement pointer |
| busy_o | output | 1 | Purge in progress |
| srch_mute_o | output | 1 | Multiple-match error suppression during a compare |
| test_flag_o | output | 1 | Search result bit |

## Verification
The search is tried with an exact address and no mask, which must hit one line; with an address equal to an unused line's tag, which shows the used qualifier at work; and with an address equal only to a reserved line's tag, which shows that reserved lines stay out. A wide mask that hits many lines at once, and the same mask with a different unmasked process field, separate the masked compare from the plain one. The purge runs over a mix of altered, clean and unused lines with commands fired into the middle of it. This separates writeback-on-altered, the per-line clearing and the ignoring of commands while busy. Pointer stepping across the wrap point, and a step that collides with a pointer reset, settle the priority.

// File: rtl/opm_pkg.sv
package opm_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_INVAL   = 3'd0,
    SEL_PTR_RST = 3'd1,
    SEL_PURGE   = 3'd2,
    SEL_MASK    = 3'd3,
    SEL_ADDR    = 3'd4
  } csr_sel_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_SCAN,
    W_WB
  } walk_e;
endpackage

// File: rtl/opm_walker.sv
module opm_walker
  import opm_pkg::*;
#(
  parameter int unsigned N_USER = 28,
  localparam int unsigned PTR_W = $clog2(N_USER)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              purge_i,
  input  logic              ptr_rst_i,
  input  logic              step_i,
  input  logic [N_USER-1:0] used_i,
  input  logic [N_USER-1:0] alt_i,
  input  logic              wb_ack_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              busy_o,
  output logic              wb_req_o,
  output logic              done_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_USER - 1);

  walk_e            state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic             done;

  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    done    = 1'b0;
    unique case (state_q)
      W_IDLE: begin
        if (purge_i) begin
          state_d = W_SCAN;
          ptr_d   = '0;
        end else if (ptr_rst_i) begin
          ptr_d = '0;
        end else if (step_i) begin
          ptr_d = ptr_inc;
        end
      end
      W_SCAN: begin
        // altered lines need a writeback before they can be dropped
        if (used_i[ptr_q] && alt_i[ptr_q]) state_d = W_WB;
        else done = 1'b1;
      end
      W_WB: done = wb_ack_i;
      default: state_d = W_IDLE;
    endcase
    if (done) begin
      ptr_d   = ptr_inc;
      state_d = (ptr_q == LAST) ? W_IDLE : W_SCAN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign busy_o   = (state_q != W_IDLE);
  assign wb_req_o = (state_q == W_WB);
  assign done_o   = done;
endmodule

// File: rtl/opm_search.sv
module opm_search #(
  parameter int unsigned N_USER = 28,
  parameter int unsigned TAG_W  = 19
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mask_we_i,
  input  logic                     addr_we_i,
  input  logic [TAG_W-1:0]         data_i,
  input  logic [N_USER*TAG_W-1:0]  tags_i,
  input  logic [N_USER-1:0]        used_i,
  output logic                     mute_o,
  output logic                     flag_o
);
  logic [TAG_W-1:0]  mask_q, addr_q;
  logic              pend_q, flag_q;
  logic [N_USER-1:0] hit;

  for (genvar g = 0; g < N_USER; g++) begin : g_cmp
    // mask bit set = tag bit is don't-care
    assign hit[g] = used_i[g] &
                    ~|((tags_i[g*TAG_W +: TAG_W] ^ addr_q) & ~mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      addr_q <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= data_i;
      if (addr_we_i) addr_q <= data_i;
      pend_q <= addr_we_i;
      if (pend_q) flag_q <= |hit;
    end
  end

  assign mute_o = pend_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/opm_clrgen.sv
module opm_clrgen #(
  parameter int unsigned N_USER  = 28,
  parameter int unsigned N_LINES = 32,
  localparam int unsigned PTR_W  = $clog2(N_USER)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inval_i,
  input  logic               done_i,
  input  logic [PTR_W-1:0]   done_idx_i,
  output logic [N_LINES-1:0] clr_o
);
  logic [N_USER-1:0] clr_d, clr_q;

  for (genvar g = 0; g < N_USER; g++) begin : g_line
    assign clr_d[g] = inval_i | (done_i && (done_idx_i == PTR_W'(g)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= '0;
    else         clr_q <= clr_d;
  end

  // reserved lines sit above the user lines and are never strobed
  assign clr_o = N_LINES'(clr_q);
endmodule

// File: rtl/opstore_maint.sv
module opstore_maint
  import opm_pkg::*;
#(
  parameter int unsigned N_USER = 28,
  parameter int unsigned N_RSVD = 4,
  parameter int unsigned TAG_W  = 19,
  parameter int unsigned VAL_W  = 64,
  localparam int unsigned N_LINES = N_USER + N_RSVD,
  localparam int unsigned IDX_W   = $clog2(N_LINES),
  localparam int unsigned PTR_W   = $clog2(N_USER)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    csr_we_i,
  input  logic [SEL_W-1:0]        csr_sel_i,
  input  logic [TAG_W-1:0]        csr_data_i,
  input  logic                    ptr_step_i,
  input  logic [N_USER*TAG_W-1:0] line_tag_i,
  input  logic [N_USER-1:0]       line_used_i,
  input  logic [N_USER-1:0]       line_alt_i,
  output logic [IDX_W-1:0]        rd_idx_o,
  input  logic [VAL_W-1:0]        rd_value_i,
  output logic                    wb_req_o,
  input  logic                    wb_ack_i,
  output logic [TAG_W-1:0]        wb_addr_o,
  output logic [VAL_W-1:0]        wb_data_o,
  output logic [N_LINES-1:0]      clr_o,
  output logic [N_USER-1:0]       ptr_o,
  output logic                    busy_o,
  output logic                    srch_mute_o,
  output logic                    test_flag_o
);
  logic             busy, acc, done;
  logic             cmd_inval, cmd_ptr_rst, cmd_purge, cmd_mask, cmd_addr;
  logic [PTR_W-1:0] ptr_q;
  logic [TAG_W-1:0] tag_a [N_USER];

  assign acc         = csr_we_i & ~busy;
  assign cmd_inval   = acc & (csr_sel_i == SEL_INVAL);
  assign cmd_ptr_rst = acc & (csr_sel_i == SEL_PTR_RST);
  assign cmd_purge   = acc & (csr_sel_i == SEL_PURGE);
  assign cmd_mask    = acc & (csr_sel_i == SEL_MASK);
  assign cmd_addr    = acc & (csr_sel_i == SEL_ADDR);

  opm_walker #(.N_USER(N_USER)) u_walker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .purge_i   (cmd_purge),
    .ptr_rst_i (cmd_ptr_rst),
    .step_i    (ptr_step_i),
    .used_i    (line_used_i),
    .alt_i     (line_alt_i),
    .wb_ack_i  (wb_ack_i),
    .ptr_o     (ptr_q),
    .busy_o    (busy),
    .wb_req_o  (wb_req_o),
    .done_o    (done)
  );

  opm_search #(.N_USER(N_USER), .TAG_W(TAG_W)) u_search (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (cmd_mask),
    .addr_we_i (cmd_addr),
    .data_i    (csr_data_i),
    .tags_i    (line_tag_i),
    .used_i    (line_used_i),
    .mute_o    (srch_mute_o),
    .flag_o    (test_flag_o)
  );

  opm_clrgen #(.N_USER(N_USER), .N_LINES(N_LINES)) u_clrgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inval_i    (cmd_inval),
    .done_i     (done),
    .done_idx_i (ptr_q),
    .clr_o      (clr_o)
  );

  for (genvar g = 0; g < N_USER; g++) begin : g_line
    assign tag_a[g] = line_tag_i[g*TAG_W +: TAG_W];
    assign ptr_o[g] = (ptr_q == PTR_W'(g));
  end

  assign rd_idx_o  = IDX_W'(ptr_q);
  assign wb_addr_o = tag_a[ptr_q];
  assign wb_data_o = rd_value_i;
  assign busy_o    = busy;
endmodule

// File: rtl/opstore_maint_chk.sv
module opstore_maint_chk #(
  parameter int unsigned N_USER  = 28,
  parameter int unsigned N_LINES = 32,
  parameter int unsigned TAG_W   = 19
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wb_req_o,
  input logic               wb_ack_i,
  input logic [TAG_W-1:0]   wb_addr_o,
  input logic [N_LINES-1:0] clr_o,
  input logic [N_USER-1:0]  ptr_o,
  input logic               busy_o,
  input logic               srch_mute_o,
  input logic               test_flag_o
);
  assert_rsvd_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o[N_LINES-1:N_USER] == '0);

  assert_wb_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_addr_o) && $stable(ptr_o));

  assert_wb_in_purge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> busy_o);

  assert_purge_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ptr_o == N_USER'(1));

  assert_purge_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $onehot0(clr_o));

  assert_flag_only_after_cmp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_mute_o |=> $stable(test_flag_o));

  assert_ptr_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ptr_o));
endmodule

bind opstore_maint opstore_maint_chk #(
  .N_USER (N_USER),
  .N_LINES(N_LINES),
  .TAG_W  (TAG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wb_req_o   (wb_req_o),
  .wb_ack_i   (wb_ack_i),
  .wb_addr_o  (wb_addr_o),
  .clr_o      (clr_o),
  .ptr_o      (ptr_o),
  .busy_o     (busy_o),
  .srch_mute_o(srch_mute_o),
  .test_flag_o(test_flag_o)
);

// File: tb/opstore_maint_bench.sv
module opstore_maint_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 28;
  localparam int NL = 32;
  localparam int TW = 19;
  localparam int VW = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csr_we = 1'b0;
  logic [2:0] csr_sel = '0;
  logic [TW-1:0] csr_data = '0;
  logic ptr_step = 1'b0;
  logic wb_ack = 1'b0;
  logic [NU*TW-1:0] line_tag;
  logic [NU-1:0] line_used, line_alt;
  logic [4:0] rd_idx;
  logic [VW-1:0] rd_value;
  logic wb_req, busy, mute, flag;
  logic [TW-1:0] wb_addr;
  logic [VW-1:0] wb_data;
  logic [NL-1:0] clr;
  logic [NU-1:0] ptr;

  // store model
  logic [TW-1:0] s_tag [NL];
  logic [VW-1:0] s_val [NL];
  logic s_used [NL];
  logic s_alt  [NL];
  logic ld_en = 1'b0;
  int ld_idx = 0;
  logic [TW-1:0] ld_tag = '0;
  logic [VW-1:0] ld_val = '0;
  logic ld_used = 1'b0, ld_alt = 1'b0;

  // reference model state
  int m_state, m_ptr;
  logic m_flag, m_pend;
  logic [TW-1:0] m_mask, m_addr;
  logic [NL-1:0] m_clr;
  int wb_count;

  int n_chk = 0, n_fail = 0;
  int ack_lat = 3, ack_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opstore_maint u_opstore_maint (
    .clk_i(clk), .rst_ni(rst_ni),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_data_i(csr_data),
    .ptr_step_i(ptr_step),
    .line_tag_i(line_tag), .line_used_i(line_used), .line_alt_i(line_alt),
    .rd_idx_o(rd_idx), .rd_value_i(rd_value),
    .wb_req_o(wb_req), .wb_ack_i(wb_ack), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .clr_o(clr), .ptr_o(ptr), .busy_o(busy), .srch_mute_o(mute), .test_flag_o(flag)
  );

  always_comb begin
    for (int i = 0; i < NU; i++) begin
      line_tag[i*TW +: TW] = s_tag[i];
      line_used[i] = s_used[i];
      line_alt[i]  = s_alt[i];
    end
    rd_value = s_val[rd_idx];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit srch_expect();
    bit h = 0;
    for (int i = 0; i < NU; i++)
      if (s_used[i] && (((s_tag[i] ^ m_addr) & ~m_mask) == '0)) h = 1;
    return h;
  endfunction

  // reference model and store, updated together at each edge
  always @(posedge clk or negedge rst_ni) begin : mdl
    int st, p;
    bit done, acc;
    logic [NL-1:0] nclr;
    if (!rst_ni) begin
      m_state <= 0; m_ptr <= 0; m_flag <= 0; m_pend <= 0;
      m_mask <= '0; m_addr <= '0; m_clr <= '0; wb_count <= 0;
      for (int i = 0; i < NL; i++) begin
        s_tag[i] <= '0; s_val[i] <= '0; s_used[i] <= 0; s_alt[i] <= 0;
      end
    end else begin
      st = m_state; p = m_ptr; done = 0; nclr = '0;
      acc = csr_we && (m_state == 0);
      if (m_state == 0) begin
        if (acc && csr_sel == 3'd2) begin st = 1; p = 0; end
        else if (acc && csr_sel == 3'd1) p = 0;
        else if (ptr_step) p = (m_ptr + 1) % NU;
        if (acc && csr_sel == 3'd0) nclr = NL'({NU{1'b1}});
      end else if (m_state == 1) begin
        if (s_used[m_ptr] && s_alt[m_ptr]) st = 2; else done = 1;
      end else begin
        done = wb_ack;
      end
      if (done) begin
        nclr[m_ptr] = 1'b1;
        p = (m_ptr + 1) % NU;
        st = (m_ptr == NU-1) ? 0 : 1;
      end
      m_state <= st; m_ptr <= p; m_clr <= nclr;
      if (acc && csr_sel == 3'd3) m_mask <= csr_data;
      if (acc && csr_sel == 3'd4) m_addr <= csr_data;
      m_pend <= acc && csr_sel == 3'd4;
      if (m_pend) m_flag <= srch_expect();
      if (wb_req && wb_ack) wb_count <= wb_count + 1;
      for (int i = 0; i < NL; i++)
        if (clr[i]) begin s_used[i] <= 0; s_alt[i] <= 0; end
      if (ld_en) begin
        s_tag[ld_idx] <= ld_tag; s_val[ld_idx] <= ld_val;
        s_used[ld_idx] <= ld_used; s_alt[ld_idx] <= ld_alt;
      end
    end
  end

  // writeback responder
  always @(negedge clk) begin
    if (wb_req && !wb_ack) begin
      if (ack_cnt >= ack_lat) begin wb_ack <= 1'b1; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end else wb_ack <= 1'b0;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk(ptr == (NU'(1) << m_ptr), "R3", "ptr_o", 64'(ptr), 64'(NU'(1) << m_ptr));
      chk(busy == (m_state != 0), "R4", "busy_o", 64'(busy), 64'(m_state != 0));
      chk(wb_req == (m_state == 2), "R5", "wb_req_o", 64'(wb_req), 64'(m_state == 2));
      chk(clr == m_clr, "R6", "clr_o", 64'(clr), 64'(m_clr));
      chk(mute == m_pend, "R9", "srch_mute_o", 64'(mute), 64'(m_pend));
      chk(flag == m_flag, "R8", "test_flag_o", 64'(flag), 64'(m_flag));
      if (m_state == 2) begin
        chk(wb_addr == s_tag[m_ptr], "R5", "wb_addr_o", 64'(wb_addr), 64'(s_tag[m_ptr]));
        chk(wb_data == s_val[m_ptr], "R5", "wb_data_o", wb_data, s_val[m_ptr]);
      end
    end
  end

  task automatic csr(input logic [2:0] sel, input logic [TW-1:0] d);
    @(negedge clk); csr_we = 1; csr_sel = sel; csr_data = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic load(input int idx, input logic [TW-1:0] t, input logic [VW-1:0] v,
                      input logic u, input logic a);
    @(negedge clk); ld_en = 1; ld_idx = idx; ld_tag = t; ld_val = v; ld_used = u; ld_alt = a;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic fill();
    for (int i = 0; i < NL; i++) begin
      if (i < NU)
        load(i, {4'h2, 15'(i*16)}, 64'hA5A5_0000_0000_0000 | 64'(i), i != 5,
             i == 3 || i == 7 || i == 27);
      else
        load(i, {4'h2, 15'h700}, 64'hC3C3_0000_0000_0000 | 64'(i), 1, 1);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int wb0, un, rs;
    logic f0;
    logic [NU-1:0] p0;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(ptr == NU'(1), "R1", "ptr_o", 64'(ptr), 1);
    chk(!busy && !wb_req && !mute && !flag, "R1", "busy/wb/mute/flag", 64'({busy, wb_req, mute, flag}), 0);
    chk(clr == '0, "R1", "clr_o", 64'(clr), 0);

    fill();

    // R3 stepping and wrap
    @(negedge clk); ptr_step = 1;
    repeat (30) @(negedge clk);
    ptr_step = 0;
    chk(ptr == NU'(1) << 2, "R3", "ptr after 30 steps", 64'(ptr), 64'(NU'(1) << 2));
    csr(3'd1, '0);
    chk(ptr == NU'(1), "R3", "ptr after reset", 64'(ptr), 1);
    @(negedge clk); ptr_step = 1;
    @(negedge clk); ptr_step = 0;
    @(negedge clk); ptr_step = 1; csr_we = 1; csr_sel = 3'd1;
    @(negedge clk); ptr_step = 0; csr_we = 0;
    chk(ptr == NU'(1), "R3", "reset beats step", 64'(ptr), 1);

    // R7/R8 searches
    csr(3'd3, '0);
    csr(3'd4, {4'h2, 15'(10*16)}); @(negedge clk);
    chk(flag == 1, "R8", "exact hit line 10", 64'(flag), 1);
    csr(3'd4, {4'h2, 15'(5*16)}); @(negedge clk);
    chk(flag == 0, "R8", "unused line no hit", 64'(flag), 0);
    csr(3'd4, {4'h2, 15'h700}); @(negedge clk);
    chk(flag == 0, "R10", "reserved tag no hit", 64'(flag), 0);
    csr(3'd3, 19'h000FF);
    csr(3'd4, {4'h2, 15'h000}); @(negedge clk);
    chk(flag == 1, "R7", "masked multi hit", 64'(flag), 1);
    csr(3'd4, {4'h3, 15'h000}); @(negedge clk);
    chk(flag == 0, "R7", "unmasked field differs", 64'(flag), 0);

    // R11 unknown select
    p0 = ptr; f0 = flag;
    csr(3'd7, {4'h2, 15'h000}); @(negedge clk);
    chk(ptr == p0 && flag == f0 && clr == '0, "R11", "select 7 ignored", 64'({ptr, flag}), 64'({p0, f0}));

    // R4/R5/R6/R11 purge from a non-zero pointer with commands fired into it
    @(negedge clk); ptr_step = 1;
    repeat (4) @(negedge clk);
    ptr_step = 0;
    wb0 = wb_count;
    csr(3'd2, '0);
    chk(busy == 1, "R4", "busy after purge", 64'(busy), 1);
    csr(3'd0, '0);
    csr(3'd4, {4'h2, 15'h000});
    @(negedge clk); ptr_step = 1;
    @(negedge clk); ptr_step = 0;
    csr(3'd1, '0);
    wait_idle();
    @(negedge clk);
    chk(wb_count - wb0 == 3, "R5", "writebacks in purge", 64'(wb_count - wb0), 3);
    un = 0; rs = 0;
    for (int i = 0; i < NU; i++) if (s_used[i]) un++;
    for (int i = NU; i < NL; i++) if (s_used[i]) rs++;
    chk(un == 0, "R6", "user lines used after purge", 64'(un), 0);
    chk(rs == NL - NU, "R10", "reserved lines after purge", 64'(rs), 64'(NL - NU));
    chk(ptr == NU'(1), "R6", "ptr after purge", 64'(ptr), 1);
    chk(flag == 0, "R11", "search during purge ignored", 64'(flag), 0);

    // R2 invalidate
    fill();
    wb0 = wb_count;
    csr(3'd0, '0);
    chk(clr == NL'({NU{1'b1}}), "R2", "clr_o on invalidate", 64'(clr), 64'(NL'({NU{1'b1}})));
    @(negedge clk);
    chk(clr == '0, "R2", "clr_o one cycle", 64'(clr), 0);
    un = 0; rs = 0;
    for (int i = 0; i < NU; i++) if (s_used[i] || s_alt[i]) un++;
    for (int i = NU; i < NL; i++) if (s_used[i]) rs++;
    chk(un == 0, "R2", "user status after invalidate", 64'(un), 0);
    chk(rs == NL - NU, "R10", "reserved after invalidate", 64'(rs), 64'(NL - NU));
    chk(wb_count == wb0 && !wb_req, "R2", "no writeback", 64'(wb_count - wb0), 0);

    // R6 purge over an empty store: fast walk, no writebacks
    ack_lat = 0;
    csr(3'd2, '0);
    wait_idle();
    chk(wb_count == wb0, "R6", "empty purge writebacks", 64'(wb_count - wb0), 0);
    chk(ptr == NU'(1), "R6", "ptr after empty purge", 64'(ptr), 1);

    // R5 short acknowledge latency
    fill();
    csr(3'd2, '0);
    wait_idle();
    @(negedge clk);
    chk(wb_count - wb0 == 3, "R5", "writebacks fast ack", 64'(wb_count - wb0), 3);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule